// File: doc/BRIEF.md
# Unpacked BCD Adjust Unit

This unit applies decimal correction to a low/high byte register pair that holds unpacked BCD digits, one digit per byte. After a plain binary addition of two unpacked digits into the low byte, the add-adjust operation turns the sum into a single valid digit. It carries a decimal carry into the high byte and reports that carry on two flag outputs. Before a division, the divide-adjust operation folds the two digits into one binary value in the low byte and clears the high byte. The number base of that fold is ten unless an immediate base byte is selected.

A start strobe launches one operation. One clock later the unit presents the new register values with a done pulse. If the operation is not legal, it presents an invalid-opcode exception pulse that carries the vector number instead. The operation is not legal when the wide-mode indicator is set or when a bus-lock prefix is present. The register file, decode and exception delivery sit outside the unit.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output register is cleared to zero.
- R2: The add-adjust (op_sel = 0) takes its correction when al_in[3:0] > 9 or af_in = 1. It then gives al_out = ((al_in + 6) mod 256) with bits 7..4 cleared, ah_out = (ah_in + 1) mod 256, and af_out = cf_out = 1. Any carry out of the low byte adds nothing to ah_out beyond that 1.
- R3: When the add-adjust does not take its correction, af_out = cf_out = 0, ah_out = ah_in, and al_out = al_in with bits 7..4 cleared.
- R4: The divide-adjust (op_sel = 1) gives al_out = (al_in + ah_in × base) mod 256 and ah_out = 0. af_out and cf_out keep the values they held before.
- R5: With imm_en = 0 the divide-adjust uses base 10 and ignores base_in. With imm_en = 1 it uses base_in, and any value from 0 to 255 is accepted.
- R6: When mode64 = 1, either operation raises exc_valid with exc_vector = 6, does not raise done, and leaves al_out, ah_out, af_out and cf_out unchanged.
- R7: When lock_pfx = 1, either operation traps in the same way as R6, whatever the value of mode64.
- R8: done or exc_valid rises exactly one clock after a start strobe, lasts one cycle, and never rises together with the other. Without a start strobe neither rises and all data outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches one operation this cycle |
| op_sel | input | 1 | 0 = add-adjust, 1 = divide-adjust |
| al_in | input | 8 | Low byte (units digit) |
| ah_in | input | 8 | High byte (tens digit) |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| imm_en | input | 1 | Use base_in as the divide base instead of 10 |
| base_in | input | 8 | Immediate divide base |
| mode64 | input | 1 | Wide execution mode active, both operations illegal |
| lock_pfx | input | 1 | Bus-lock prefix present, both operations illegal |
| al_out | output | 8 | New low byte |
| ah_out | output | 8 | New high byte |
| af_out | output | 1 | New auxiliary-carry flag |
| cf_out | output | 1 | New carry flag |
| done | output | 1 | Result valid pulse |
| exc_valid | output | 1 | Invalid-opcode exception pulse |
| exc_vector | output | 8 | Exception vector number (6) |

## Verification
The bench builds the unit with its default parameters: 8-bit bytes, base ten, vector 6 and the immediate base enabled. At that size the whole add-adjust input space of low byte and incoming flag can be swept against three high-byte values, which covers the 0xFF wrap. The divide-adjust is swept over every high byte at several low bytes, and every immediate base is tried. Trap cases cover both indicators on both operations and confirm that the previous results stay in place.

// File: rtl/bcd_adj_pkg.sv
// Shared definitions for the unpacked BCD adjust unit.
// Assumes a single-bit operation select.
package bcd_adj_pkg;

    typedef enum logic {
        OP_ADD_ADJ = 1'b0,
        OP_DIV_ADJ = 1'b1
    } adj_op_e;

    localparam int NIB_W     = 4;
    localparam int DIGIT_MAX = 9;
    localparam int ADD_CORR  = 6;

endpackage

// File: rtl/bcd_trap_check.sv
// Decides whether an adjust request must trap as an invalid opcode.
// Assumes both indicators are valid in the start cycle.
module bcd_trap_check (
    input  logic mode64_i,
    input  logic lock_i,
    output logic trap_o
);
    // Either indicator makes both operations illegal.
    always_comb trap_o = mode64_i | lock_i;
endmodule

// File: rtl/bcd_add_adjust.sv
// Combinational after-addition correction of one unpacked digit.
// Assumes the low byte came from a binary add of two digits; only its low nibble matters.
module bcd_add_adjust
    import bcd_adj_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NIB_W-1:0]  al_lo_i,
    input  logic [DATA_W-1:0] ah_i,
    input  logic              af_i,
    output logic [DATA_W-1:0] al_o,
    output logic [DATA_W-1:0] ah_o,
    output logic              carry_o
);
    localparam logic [NIB_W-1:0]  CORR  = NIB_W'(ADD_CORR);
    localparam logic [NIB_W-1:0]  LIMIT = NIB_W'(DIGIT_MAX);
    localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);

    logic take;

    // Correction decision, new digit and high-byte increment.
    always_comb begin
        take    = (al_lo_i > LIMIT) | af_i;
        carry_o = take;
        al_o    = '0;
        if (take) begin
            al_o[NIB_W-1:0] = al_lo_i + CORR;
            ah_o            = ah_i + ONE;
        end else begin
            al_o[NIB_W-1:0] = al_lo_i;
            ah_o            = ah_i;
        end
    end
endmodule

// File: rtl/bcd_div_adjust.sv
// Combinational before-division fold of two digits into one binary byte.
// Assumes the result wraps at the byte width; the base may be any byte value.
module bcd_div_adjust #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] al_i,
    input  logic [DATA_W-1:0] ah_i,
    input  logic [DATA_W-1:0] base_i,
    output logic [DATA_W-1:0] al_o,
    output logic [DATA_W-1:0] ah_o
);
    logic [DATA_W-1:0] prod;

    // Weighted high digit plus low digit, modulo the byte width.
    always_comb begin
        prod = ah_i * base_i;
        al_o = al_i + prod;
        ah_o = '0;
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
// Top of the unpacked BCD adjust unit: selects the adjust path, applies
// invalid-opcode trapping and registers all results one cycle after start.
// Assumes inputs are stable in the start cycle; reset is synchronous, active low.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int VEC_W          = 8,
    parameter int UD_VECTOR      = 6,
    parameter int DEF_BASE       = 10,
    parameter bit ALLOW_IMM_BASE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sel,
    input  logic [DATA_W-1:0] al_in,
    input  logic [DATA_W-1:0] ah_in,
    input  logic              af_in,
    input  logic              imm_en,
    input  logic [DATA_W-1:0] base_in,
    input  logic              mode64,
    input  logic              lock_pfx,
    output logic [DATA_W-1:0] al_out,
    output logic [DATA_W-1:0] ah_out,
    output logic              af_out,
    output logic              cf_out,
    output logic              done,
    output logic              exc_valid,
    output logic [VEC_W-1:0]  exc_vector
);
    localparam logic [DATA_W-1:0] BASE_DEF = DATA_W'(DEF_BASE);
    localparam logic [VEC_W-1:0]  VEC_UD   = VEC_W'(UD_VECTOR);

    adj_op_e           op;
    logic              trap;
    logic [DATA_W-1:0] base_sel;
    logic [DATA_W-1:0] add_al, add_ah, div_al, div_ah;
    logic              add_carry;

    // Map the raw select onto the operation type.
    always_comb op = adj_op_e'(op_sel);

    // Pick the divide base: the immediate only when the variant allows it.
    generate
        if (ALLOW_IMM_BASE) begin : g_imm_base
            always_comb base_sel = imm_en ? base_in : BASE_DEF;
        end else begin : g_fixed_base
            logic unused_imm;
            always_comb unused_imm = imm_en ^ (^base_in);
            always_comb base_sel = BASE_DEF;
        end
    endgenerate

    bcd_trap_check i_trap (
        .mode64_i (mode64),
        .lock_i   (lock_pfx),
        .trap_o   (trap)
    );

    bcd_add_adjust #(.DATA_W(DATA_W)) i_add (
        .al_lo_i (al_in[NIB_W-1:0]),
        .ah_i    (ah_in),
        .af_i    (af_in),
        .al_o    (add_al),
        .ah_o    (add_ah),
        .carry_o (add_carry)
    );

    bcd_div_adjust #(.DATA_W(DATA_W)) i_div (
        .al_i   (al_in),
        .ah_i   (ah_in),
        .base_i (base_sel),
        .al_o   (div_al),
        .ah_o   (div_ah)
    );

    // Register results, strobes and exception on a start; hold data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_out     <= '0;
            ah_out     <= '0;
            af_out     <= 1'b0;
            cf_out     <= 1'b0;
            done       <= 1'b0;
            exc_valid  <= 1'b0;
            exc_vector <= '0;
        end else begin
            done      <= 1'b0;
            exc_valid <= 1'b0;
            if (start) begin
                if (trap) begin
                    exc_valid  <= 1'b1;
                    exc_vector <= VEC_UD;
                end else begin
                    done <= 1'b1;
                    if (op == OP_ADD_ADJ) begin
                        al_out <= add_al;
                        ah_out <= add_ah;
                        af_out <= add_carry;
                        cf_out <= add_carry;
                    end else begin
                        al_out <= div_al;
                        ah_out <= div_ah;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bcd_adjust_checker.sv
// Property checker for the unpacked BCD adjust unit, bound to the top.
// Assumes default widths; observes ports only.
module bcd_adjust_checker #(
    parameter int DATA_W    = 8,
    parameter int VEC_W     = 8,
    parameter int UD_VECTOR = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_sel,
    input logic              mode64,
    input logic              lock_pfx,
    input logic [DATA_W-1:0] al_out,
    input logic [DATA_W-1:0] ah_out,
    input logic              af_out,
    input logic              cf_out,
    input logic              done,
    input logic              exc_valid,
    input logic [VEC_W-1:0]  exc_vector
);
    // R2/R3: add-adjust always leaves a single digit with equal flags.
    p_add_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op_sel && !mode64 && !lock_pfx) |=> (al_out[DATA_W-1:4] == '0) && (af_out == cf_out));

    // R4: divide-adjust clears the high byte and keeps the flags.
    p_div_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_sel && !mode64 && !lock_pfx) |=> (ah_out == '0) && $stable(af_out) && $stable(cf_out));

    // R6: wide mode traps with the fixed vector and no result.
    p_mode_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode64) |=> exc_valid && !done && (exc_vector == VEC_W'(UD_VECTOR)));

    // R7: lock prefix traps in the same way.
    p_lock_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && lock_pfx) |=> exc_valid && !done);

    // R6: a trap leaves the data outputs untouched.
    p_trap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $stable(al_out) && $stable(ah_out) && $stable(af_out) && $stable(cf_out));

    // R8: legal start gives done next cycle.
    p_done_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mode64 && !lock_pfx) |=> done && !exc_valid);

    // R8: no start means no strobe and held data.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done && !exc_valid && $stable(al_out) && $stable(ah_out));

    // R8: the two strobes never coincide.
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exc_valid));
endmodule

bind bcd_adjust_unit bcd_adjust_checker i_chk (.*);

// File: tb/test_bcd_adjust_unit.sv
// Sweep bench for the unpacked BCD adjust unit at default parameters.
module test_bcd_adjust_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, op_sel = 1'b0, af_in = 1'b0, imm_en = 1'b0;
    logic       mode64 = 1'b0, lock_pfx = 1'b0;
    logic [7:0] al_in = '0, ah_in = '0, base_in = '0;
    logic [7:0] al_out, ah_out, exc_vector;
    logic       af_out, cf_out, done, exc_valid;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_al = 0, m_ah = 0;
    logic       m_af = 0, m_cf = 0;

    always #10 clk = ~clk;

    bcd_adjust_unit i_bcd_adjust_unit (.*);

    task automatic chk(input bit ok, input string req, input string got, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %s expected %s", req, got, exp);
        end
    endtask

    // One operation: drive at negedge, sample at the following negedge.
    task automatic run_op(input bit op, input int al, input int ah, input bit af,
                          input bit imm, input int base, input bit m64, input bit lk,
                          input string req);
        int e_al, e_ah, b;
        bit trap, e_af, e_cf;
        trap = m64 | lk;
        e_al = m_al; e_ah = m_ah; e_af = m_af; e_cf = m_cf;
        if (!trap) begin
            if (!op) begin
                if ((al % 16) > 9 || af) begin
                    e_al = ((al + 6) % 256) % 16; e_ah = (ah + 1) % 256; e_af = 1; e_cf = 1;
                end else begin
                    e_al = al % 16; e_ah = ah; e_af = 0; e_cf = 0;
                end
            end else begin
                b = imm ? base : 10;
                e_al = (al + ah * b) % 256; e_ah = 0;
            end
        end
        @(negedge clk);
        start = 1; op_sel = op; al_in = 8'(al); ah_in = 8'(ah); af_in = af;
        imm_en = imm; base_in = 8'(base); mode64 = m64; lock_pfx = lk;
        @(negedge clk);
        start = 0;
        chk({al_out, ah_out, af_out, cf_out} == {8'(e_al), 8'(e_ah), e_af, e_cf}, req,
            $sformatf("al=%0d ah=%0d af=%0b cf=%0b", al_out, ah_out, af_out, cf_out),
            $sformatf("al=%0d ah=%0d af=%0b cf=%0b", e_al, e_ah, e_af, e_cf));
        chk(done == !trap && exc_valid == trap && (!trap || exc_vector == 8'd6),
            trap ? (m64 ? "R6" : "R7") : "R8",
            $sformatf("done=%0b exc=%0b vec=%0d", done, exc_valid, exc_vector),
            $sformatf("done=%0b exc=%0b vec=6", !trap, trap));
        m_al = 8'(e_al); m_ah = 8'(e_ah); m_af = e_af; m_cf = e_cf;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ahs[3] = '{0, 127, 255};
        int als[4] = '{0, 5, 9, 255};
        repeat (2) @(negedge clk);
        // R1: cleared outputs under reset.
        chk({al_out, ah_out, af_out, cf_out, done, exc_valid, exc_vector} == '0, "R1",
            $sformatf("%h", {al_out, ah_out, exc_vector}), "0");
        rst_n = 1;
        // R2 and R3: full add-adjust sweep.
        foreach (ahs[k])
            for (int a = 0; a < 256; a++)
                for (int f = 0; f < 2; f++)
                    run_op(0, a, ahs[k], f[0], 0, 0, 0, 0,
                           ((a % 16) > 9 || f != 0) ? "R2" : "R3");
        // R4 with default base, R5 ignores base_in when imm_en = 0.
        foreach (als[k])
            for (int h = 0; h < 256; h++)
                run_op(1, als[k], h, 0, 0, 3, 0, 0, "R5");
        // R4 flags kept after a taken add-adjust.
        run_op(0, 9, 1, 1, 0, 0, 0, 0, "R2");
        run_op(1, 7, 4, 0, 0, 0, 0, 0, "R4");
        // R5 every immediate base.
        for (int b = 0; b < 256; b++)
            run_op(1, 8'h37, 8'h2C, 0, 1, b, 0, 0, "R5");
        // R6 and R7 traps on both operations.
        run_op(0, 3, 3, 0, 0, 0, 0, 0, "R3");
        for (int o = 0; o < 2; o++) begin
            run_op(o[0], 15, 9, 1, 0, 0, 1, 0, "R6");
            run_op(o[0], 15, 9, 1, 1, 7, 0, 1, "R7");
            run_op(o[0], 12, 2, 0, 0, 0, 1, 1, "R7");
        end
        // R8: idle cycles leave everything held.
        repeat (3) begin
            @(negedge clk);
            chk(!done && !exc_valid && al_out == m_al && ah_out == m_ah, "R8",
                $sformatf("done=%0b exc=%0b al=%0d", done, exc_valid, al_out),
                $sformatf("done=0 exc=0 al=%0d", m_al));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule